// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream, which marks each frame's first and last byte and carries an error flag. It places each frame into the data buffer that belongs to the descriptor it is currently pointing at. A small ring of receive descriptors is held in on-chip storage. Each descriptor owns a fixed slice of an internal buffer RAM. When a frame ends, the writer stores the byte count and the completion status back into the descriptor. It then moves on to the next descriptor, or returns to descriptor 0 if the current one carries the wrap mark.

The host owns the ring from the other side. It hands a descriptor to the writer by writing it, which marks it empty and clears its length. It reads completed descriptors and buffer bytes through registered read ports. If a frame starts while the current descriptor is still held by the host, the writer discards the frame, raises a busy event and halts reception. Reception stays halted until the host resumes it explicitly. A graceful stop request lets the frame in progress finish, then parks the writer and raises a stop-complete event.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset every descriptor status byte reads 0x00 with length 0, `wr_idx` is 0, and `evt_busy`, `evt_grsc`, `rx_halted` and `rx_stopped` are all 0.
- R2: A frame is written only into the descriptor at `wr_idx`, and only while that descriptor's empty bit (status bit 7) is set. Byte k of the frame lands at buffer address `wr_idx*BUF_BYTES + k`.
- R3: At the frame's last byte the descriptor is written back. The empty bit is cleared, the last bit (bit 5) is set, the wrap bit (bit 6) is kept, and the length equals the number of stored bytes, which includes the 4 trailing FCS bytes.
- R4: After a write-back `wr_idx` becomes 0 if the completed descriptor has its wrap bit set, and `wr_idx+1` otherwise. `wr_idx` changes at no other time.
- R5: The storage limit is the smaller of `max_len` and `BUF_BYTES`. Bytes beyond the limit are discarded, the truncation bit (bit 1) is set, and the length equals the limit.
- R6: A frame with `in_err` set on any of its bytes is still stored and written back, with the error bit (bit 0) set.
- R7: A written-back length below `min_len` sets the short bit (bit 2).
- R8: A frame that starts while the descriptor at `wr_idx` is not empty is discarded. `evt_busy` and `rx_halted` are set and `wr_idx` is unchanged.
- R9: While `rx_halted` is 1, every frame is discarded, even into an empty descriptor. Only a `rhalt_clr` pulse clears the halt.
- R10: Events are cleared by writing one: `evt_clr_busy` clears `evt_busy` and `evt_clr_grsc` clears `evt_grsc`. Clearing `evt_busy` does not end the halt.
- R11: While `grs_req` is high, the frame in progress completes. The writer then sets `rx_stopped` and `evt_grsc` and discards later frames. Dropping `grs_req` resumes reception.
- R12: A host descriptor write sets status to empty plus the given wrap bit (all other bits 0) and sets the length to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_len | input | LEN_W | Programmed maximum stored bytes per frame |
| min_len | input | LEN_W | Programmed minimum frame length (short threshold) |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error flag for the current byte |
| in_data | input | 8 | Stream byte |
| host_desc_we | input | 1 | Host gives a descriptor back to the writer |
| host_desc_idx | input | clog2(RING_DEPTH) | Descriptor written by the host |
| host_desc_wrap | input | 1 | Wrap bit for the host write |
| host_rd_idx | input | clog2(RING_DEPTH) | Descriptor to read |
| host_rd_stat | output | 8 | Status byte of the descriptor read (one cycle latency) |
| host_rd_len | output | LEN_W | Length of the descriptor read (one cycle latency) |
| buf_rd_addr | input | clog2(RING_DEPTH*BUF_BYTES) | Buffer byte address to read |
| buf_rd_data | output | 8 | Buffer byte (one cycle latency) |
| grs_req | input | 1 | Graceful receive stop request (level) |
| evt_clr_busy | input | 1 | Write-one-to-clear pulse for the busy event |
| evt_clr_grsc | input | 1 | Write-one-to-clear pulse for the stop-complete event |
| rhalt_clr | input | 1 | Pulse that resumes a halted writer |
| evt_busy | output | 1 | Busy event: a frame met a non-empty descriptor |
| evt_grsc | output | 1 | Graceful stop complete event |
| rx_halted | output | 1 | Receive halted after a busy event |
| rx_stopped | output | 1 | Writer parked by a graceful stop |
| wr_idx | output | clog2(RING_DEPTH) | Descriptor the next frame will use |

## Verification
The bench sweeps the frame length across the storage limit for two limit settings. This catches an off-by-one at the limit: such a design would store one byte too many or flag truncation one byte early. The ring is shortened with a wrap bit on a middle descriptor, so a design that wraps only at the array end would move into the unused descriptor. The bench fills the ring to exhaustion and then recycles a descriptor while the writer is still halted. A design that resumes on the recycle, or on clearing the busy event alone, would write that frame. A stop request raised in the middle of a frame must still let the frame complete. A design that stops at once would lose its tail and leave the descriptor empty.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SKIP = 2'd2
  } rxr_state_t;

  // status byte: [7] empty, [6] wrap, [5] last, [4:3] zero,
  // [2] short, [1] truncated, [0] receive error
  typedef struct packed {
    logic       empty;
    logic       wrap;
    logic       last;
    logic [1:0] rsvd;
    logic       short_f;
    logic       trunc;
    logic       err;
  } rxr_stat_t;

  function automatic rxr_stat_t rxr_fresh_stat(input logic wrap);
    rxr_stat_t s;
    s       = '0;
    s.empty = 1'b1;
    s.wrap  = wrap;
    return s;
  endfunction

endpackage

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring
  import rxr_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int LEN_W      = 16,
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic             host_wrap,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic [7:0]       host_rd_stat,
  output logic [LEN_W-1:0] host_rd_len,
  input  logic             wb_fire,
  input  logic [IDX_W-1:0] wb_idx,
  input  rxr_stat_t        wb_stat,
  input  logic [LEN_W-1:0] wb_len,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             cur_empty,
  output logic             cur_wrap
);

  rxr_stat_t        stat_q [RING_DEPTH];
  logic [LEN_W-1:0] len_q  [RING_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RING_DEPTH; i++) begin
        stat_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      if (host_we) begin
        stat_q[host_idx] <= rxr_fresh_stat(host_wrap);
        len_q[host_idx]  <= '0;
      end
      // a completing frame wins over a host write to the same slot
      if (wb_fire) begin
        stat_q[wb_idx] <= wb_stat;
        len_q[wb_idx]  <= wb_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rd_stat <= '0;
      host_rd_len  <= '0;
    end else begin
      host_rd_stat <= stat_q[host_rd_idx];
      host_rd_len  <= len_q[host_rd_idx];
    end
  end

  always_comb begin
    cur_empty = stat_q[cur_idx].empty;
    cur_wrap  = stat_q[cur_idx].wrap;
  end

endmodule

// File: rtl/rxr_buf_ram.sv
module rxr_buf_ram #(
  parameter int WORDS   = 256,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
  import rxr_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int BUF_BYTES  = 32,
  parameter int LEN_W      = 16,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int OFF_W     = $clog2(BUF_BYTES),
  localparam int ADDR_W    = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic [7:0]        in_data,
  input  logic [LEN_W-1:0]  lim,
  input  logic [LEN_W-1:0]  min_len,
  input  logic              cur_empty,
  input  logic              cur_wrap,
  input  logic              grs_req,
  input  logic              clr_busy,
  input  logic              clr_grsc,
  input  logic              rhalt_clr,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              wb_fire,
  output rxr_stat_t         wb_stat,
  output logic [LEN_W-1:0]  wb_len,
  output logic              busy_set,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              evt_busy,
  output logic              evt_grsc,
  output logic              halted,
  output logic              stopped
);

  rxr_state_t       st, st_n;
  logic [LEN_W-1:0] cnt, cnt_n, cnt_base, cnt_acc;
  logic             trunc, trunc_n, tr_acc;
  logic             err, err_n, er_acc;
  logic             take, fill;
  logic [IDX_W-1:0] idx_n;
  logic             stopped_n;

  always_comb begin
    cnt_base = (st == ST_IDLE) ? '0 : cnt;
    take     = cnt_base < lim;
    cnt_acc  = take ? cnt_base + 1'b1 : cnt_base;
    tr_acc   = ((st == ST_IDLE) ? 1'b0 : trunc) | ~take;
    er_acc   = ((st == ST_IDLE) ? 1'b0 : err) | in_err;
  end

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    trunc_n  = trunc;
    err_n    = err;
    idx_n    = wr_idx;
    buf_we   = 1'b0;
    wb_fire  = 1'b0;
    busy_set = 1'b0;
    fill     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (in_valid && in_sof) begin
          if (halted || stopped) begin
            if (!in_eof) st_n = ST_SKIP;
          end else if (!cur_empty) begin
            busy_set = 1'b1;
            if (!in_eof) st_n = ST_SKIP;
          end else begin
            fill = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) fill = 1'b1;
      end
      ST_SKIP: begin
        if (in_valid && in_eof) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (fill) begin
      buf_we  = take;
      cnt_n   = cnt_acc;
      trunc_n = tr_acc;
      err_n   = er_acc;
      if (in_eof) begin
        wb_fire = 1'b1;
        st_n    = ST_IDLE;
        idx_n   = cur_wrap ? '0 : wr_idx + 1'b1;
      end else begin
        st_n = ST_FILL;
      end
    end
  end

  always_comb begin
    buf_waddr       = {wr_idx, cnt_base[OFF_W-1:0]};
    buf_wdata       = in_data;
    wb_len          = cnt_acc;
    wb_stat         = '0;
    wb_stat.wrap    = cur_wrap;
    wb_stat.last    = 1'b1;
    wb_stat.short_f = cnt_acc < min_len;
    wb_stat.trunc   = tr_acc;
    wb_stat.err     = er_acc;
  end

  // park only at a frame boundary
  assign stopped_n = grs_req & (stopped | (st_n == ST_IDLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      trunc    <= 1'b0;
      err      <= 1'b0;
      wr_idx   <= '0;
      evt_busy <= 1'b0;
      evt_grsc <= 1'b0;
      halted   <= 1'b0;
      stopped  <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      trunc    <= trunc_n;
      err      <= err_n;
      wr_idx   <= idx_n;
      evt_busy <= (evt_busy & ~clr_busy) | busy_set;
      evt_grsc <= (evt_grsc & ~clr_grsc) | (stopped_n & ~stopped);
      halted   <= (halted & ~rhalt_clr) | busy_set;
      stopped  <= stopped_n;
    end
  end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int BUF_BYTES  = 32,
  parameter int LEN_W      = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [LEN_W-1:0]                       max_len,
  input  logic [LEN_W-1:0]                       min_len,
  input  logic                                   in_valid,
  input  logic                                   in_sof,
  input  logic                                   in_eof,
  input  logic                                   in_err,
  input  logic [7:0]                             in_data,
  input  logic                                   host_desc_we,
  input  logic [$clog2(RING_DEPTH)-1:0]          host_desc_idx,
  input  logic                                   host_desc_wrap,
  input  logic [$clog2(RING_DEPTH)-1:0]          host_rd_idx,
  output logic [7:0]                             host_rd_stat,
  output logic [LEN_W-1:0]                       host_rd_len,
  input  logic [$clog2(RING_DEPTH*BUF_BYTES)-1:0] buf_rd_addr,
  output logic [7:0]                             buf_rd_data,
  input  logic                                   grs_req,
  input  logic                                   evt_clr_busy,
  input  logic                                   evt_clr_grsc,
  input  logic                                   rhalt_clr,
  output logic                                   evt_busy,
  output logic                                   evt_grsc,
  output logic                                   rx_halted,
  output logic                                   rx_stopped,
  output logic [$clog2(RING_DEPTH)-1:0]          wr_idx
);

  localparam int IDX_W  = $clog2(RING_DEPTH);
  localparam int WORDS  = RING_DEPTH * BUF_BYTES;
  localparam int ADDR_W = $clog2(WORDS);
  localparam logic [LEN_W-1:0] BUF_CAP = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0]  lim;
  logic              cur_empty, cur_wrap;
  logic              buf_we;
  logic [ADDR_W-1:0] buf_waddr;
  logic [7:0]        buf_wdata;
  logic              wb_fire;
  rxr_stat_t         wb_stat;
  logic [LEN_W-1:0]  wb_len;
  logic              busy_set;

  assign lim = (max_len > BUF_CAP) ? BUF_CAP : max_len;

  rxr_fsm #(
    .RING_DEPTH(RING_DEPTH), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_data(in_data),
    .lim(lim), .min_len(min_len),
    .cur_empty(cur_empty), .cur_wrap(cur_wrap),
    .grs_req(grs_req), .clr_busy(evt_clr_busy), .clr_grsc(evt_clr_grsc),
    .rhalt_clr(rhalt_clr),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .wb_fire(wb_fire), .wb_stat(wb_stat), .wb_len(wb_len),
    .busy_set(busy_set), .wr_idx(wr_idx),
    .evt_busy(evt_busy), .evt_grsc(evt_grsc),
    .halted(rx_halted), .stopped(rx_stopped)
  );

  rxr_desc_ring #(
    .RING_DEPTH(RING_DEPTH), .LEN_W(LEN_W)
  ) u_ring (
    .clk(clk), .rst(rst),
    .host_we(host_desc_we), .host_idx(host_desc_idx), .host_wrap(host_desc_wrap),
    .host_rd_idx(host_rd_idx), .host_rd_stat(host_rd_stat), .host_rd_len(host_rd_len),
    .wb_fire(wb_fire), .wb_idx(wr_idx), .wb_stat(wb_stat), .wb_len(wb_len),
    .cur_idx(wr_idx), .cur_empty(cur_empty), .cur_wrap(cur_wrap)
  );

  rxr_buf_ram #(
    .WORDS(WORDS)
  ) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_rd_addr), .rdata(buf_rd_data)
  );

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int RING_DEPTH = 8,
  parameter int LEN_W      = 16,
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_fire,
  input logic [LEN_W-1:0] wb_len,
  input logic [LEN_W-1:0] lim,
  input logic             cur_empty,
  input logic             busy_set,
  input logic             evt_clr_busy,
  input logic             rhalt_clr,
  input logic             evt_busy,
  input logic             evt_grsc,
  input logic             rx_halted,
  input logic             rx_stopped,
  input logic [IDX_W-1:0] wr_idx
);

  AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> cur_empty); // R2
  AST_IDX_STEADY: assert property (@(posedge clk) disable iff (rst)
    !wb_fire |=> $stable(wr_idx)); // R4
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> (wb_len <= lim)); // R5
  AST_BUSY_HALTS: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_busy) |-> rx_halted); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rx_halted && !rhalt_clr) |=> rx_halted); // R9
  AST_BUSY_W1C: assert property (@(posedge clk) disable iff (rst)
    (evt_clr_busy && !busy_set) |=> !evt_busy); // R10
  AST_GRSC_STOPPED: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_grsc) |-> rx_stopped); // R11

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
  .RING_DEPTH(RING_DEPTH), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .wb_fire(wb_fire), .wb_len(wb_len), .lim(lim),
  .cur_empty(cur_empty), .busy_set(busy_set), .evt_clr_busy(evt_clr_busy),
  .rhalt_clr(rhalt_clr), .evt_busy(evt_busy), .evt_grsc(evt_grsc),
  .rx_halted(rx_halted), .rx_stopped(rx_stopped), .wr_idx(wr_idx)
);

// File: tb/rxr_ring_writer_test.sv
module rxr_ring_writer_test;
  localparam int DEPTH = 4;
  localparam int BUFB  = 16;
  localparam int LW    = 16;
  localparam int WRAPI = 2;   // ring shortened to descriptors 0..2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] max_len = 16, min_len = 6;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic host_desc_we = 0, host_desc_wrap = 0;
  logic [1:0] host_desc_idx = 0, host_rd_idx = 0;
  logic [7:0] host_rd_stat;
  logic [LW-1:0] host_rd_len;
  logic [5:0] buf_rd_addr = 0;
  logic [7:0] buf_rd_data;
  logic grs_req = 0, evt_clr_busy = 0, evt_clr_grsc = 0, rhalt_clr = 0;
  logic evt_busy, evt_grsc, rx_halted, rx_stopped;
  logic [1:0] wr_idx;

  int n_chk = 0, n_bad = 0;
  int exp_idx = 0;
  int seed = 0;

  always #4 clk = ~clk;

  rxr_ring_writer #(.RING_DEPTH(DEPTH), .BUF_BYTES(BUFB), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst), .max_len(max_len), .min_len(min_len),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .in_data(in_data), .host_desc_we(host_desc_we), .host_desc_idx(host_desc_idx),
    .host_desc_wrap(host_desc_wrap), .host_rd_idx(host_rd_idx),
    .host_rd_stat(host_rd_stat), .host_rd_len(host_rd_len),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .grs_req(grs_req),
    .evt_clr_busy(evt_clr_busy), .evt_clr_grsc(evt_clr_grsc), .rhalt_clr(rhalt_clr),
    .evt_busy(evt_busy), .evt_grsc(evt_grsc), .rx_halted(rx_halted),
    .rx_stopped(rx_stopped), .wr_idx(wr_idx)
  );

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 13 + i * 7 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_host(input int idx);
    @(negedge clk);
    host_desc_we = 1; host_desc_idx = 2'(idx); host_desc_wrap = (idx == WRAPI);
    @(negedge clk);
    host_desc_we = 0;
  endtask

  task automatic read_desc(input int idx, output int st, output int ln);
    @(negedge clk);
    host_rd_idx = 2'(idx);
    @(negedge clk);
    st = host_rd_stat; ln = host_rd_len;
  endtask

  task automatic send(input int len, input bit err, input int grs_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_err = err && (i == len / 2); in_data = pat(seed, i);
      if (i == grs_at) grs_req = 1;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
  endtask

  // frame accepted into exp_idx: check descriptor, bytes, index advance
  task automatic frame_ok(input int len, input bit err, input int grs_at);
    int st, ln, lim, stored, es;
    lim = (int'(max_len) > BUFB) ? BUFB : int'(max_len);
    send(len, err, grs_at);
    stored = (len > lim) ? lim : len;
    es = 8'h20 | ((exp_idx == WRAPI) ? 8'h40 : 0) | ((stored < int'(min_len)) ? 4 : 0)
       | ((len > lim) ? 2 : 0) | (err ? 1 : 0);
    read_desc(exp_idx, st, ln);
    check("R3/R5/R6/R7 status", st, es);
    check("R3/R5 length", ln, stored);
    for (int i = 0; i < stored; i++) begin
      @(negedge clk); buf_rd_addr = 6'(exp_idx * BUFB + i);
      @(negedge clk); check("R2 data byte", buf_rd_data, pat(seed, i));
    end
    exp_idx = (exp_idx == WRAPI) ? 0 : exp_idx + 1;
    check("R4 next index", wr_idx, exp_idx);
    seed++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int st, ln, hold;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    read_desc(0, st, ln);
    check("R1 status", st, 0); check("R1 length", ln, 0);
    check("R1 wr_idx", wr_idx, 0); check("R1 busy", evt_busy, 0);
    check("R1 grsc", evt_grsc, 0); check("R1 halted", rx_halted, 0);
    check("R1 stopped", rx_stopped, 0);
    // R12 host give-back
    for (int d = 0; d < DEPTH; d++) pulse_host(d);
    read_desc(WRAPI, st, ln);
    check("R12 status", st, 8'hC0); check("R12 length", ln, 0);
    // sweep lengths over limit 16, recycling each descriptor
    for (int l = 1; l <= 20; l++) begin
      hold = exp_idx;
      frame_ok(l, (l % 5) == 0, -1);
      pulse_host(hold);
    end
    max_len = 9;
    for (int l = 7; l <= 12; l++) begin
      hold = exp_idx; frame_ok(l, l == 8, -1); pulse_host(hold);
    end
    max_len = 40;  // clamp to buffer size
    hold = exp_idx; frame_ok(20, 0, -1); pulse_host(hold);
    max_len = 16;
    // R8 exhaust the ring
    for (int k = 0; k < 3; k++) frame_ok(10, 0, -1);
    hold = exp_idx;
    send(8, 0, -1);
    check("R8 busy set", evt_busy, 1); check("R8 halted", rx_halted, 1);
    check("R8 index held", wr_idx, hold);
    read_desc(hold, st, ln);
    check("R8 descriptor untouched", st, 8'h20 | ((hold == WRAPI) ? 8'h40 : 0));
    check("R8 length untouched", ln, 10);
    // R9 recycle while halted: frame still dropped
    for (int d = 0; d < 3; d++) pulse_host(d);
    send(8, 0, -1);
    read_desc(hold, st, ln);
    check("R9 dropped status", st, 8'h80 | ((hold == WRAPI) ? 8'h40 : 0));
    check("R9 dropped length", ln, 0);
    check("R9 index held", wr_idx, hold);
    // R10 clear busy, halt remains
    @(negedge clk); evt_clr_busy = 1; @(negedge clk); evt_clr_busy = 0;
    check("R10 busy cleared", evt_busy, 0); check("R10 still halted", rx_halted, 1);
    @(negedge clk); rhalt_clr = 1; @(negedge clk); rhalt_clr = 0;
    check("R9 resumed", rx_halted, 0);
    hold = exp_idx; frame_ok(12, 0, -1); pulse_host(hold);
    // R11 stop requested mid-frame
    hold = exp_idx; frame_ok(14, 0, 3); pulse_host(hold);
    check("R11 stopped", rx_stopped, 1); check("R11 event", evt_grsc, 1);
    send(6, 0, -1);
    check("R11 index held", wr_idx, exp_idx);
    read_desc(exp_idx, st, ln);
    check("R11 dropped length", ln, 0);
    @(negedge clk); grs_req = 0; evt_clr_grsc = 1; @(negedge clk); evt_clr_grsc = 0;
    check("R10 grsc cleared", evt_grsc, 0); check("R11 released", rx_stopped, 0);
    hold = exp_idx; frame_ok(7, 1, -1); pulse_host(hold);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule